// File: doc/BRIEF.md
# Dual-Port Configuration Register Bank

This block holds the configuration of a three-channel video front end. It can be written over either of two host ports that share the same three control pins. The first is a three-wire serial port: enable, data and clock. The second is a strobed byte-wide parallel port that carries an address/data select and a direction line. Which port is live is decided once, from the level of the shared enable/strobe pin while hardware reset is held, and it stays fixed until the next hardware reset.

The bank contains four setup registers, a write-only software reset location, and three per-channel register sets: an 8-bit offset magnitude, an offset sign and a 5-bit gain code. A per-channel write carries a two-bit channel selector. Selector codes 0 to 2 pick one channel, and code 3 updates all three in the same cycle. All pins are sampled in the system clock domain through synchronisers. Writes are detected from edges of the synchronised pins.

Top module: `cfg_port_regs`

## Requirements
- R1: While `rstN` is low the port type follows `enStb` (0 = serial, 1 = parallel), and `parMode` keeps the value held at reset release; a software reset leaves `parMode` unchanged.
- R2: In serial mode each rising edge of `sckRnw` shifts in `sdiDna`. A rising edge of `enStb` commits the last 14 bits shifted, taken MSB first as a 6-bit address followed by an 8-bit data byte.
- R3: In parallel mode a write happens when `enStb` returns high after a low period with `sckRnw` low. `sdiDna` low latches `busIn[5:0]` as the address, and `sdiDna` high writes `busIn` to the latched address. Further data bytes reuse the same address. A strobe taken with `sckRnw` high writes nothing.
- R4: A parallel data byte sent before any address byte since the last hardware reset is ignored. Pin levels that are present while reset is released do not count as a strobe.
- R5: `busOe` is 1 exactly when the block is in parallel mode and `sckRnw` is high; in serial mode it is 0.
- R6: Setup registers live at 000001 (reset value 03h), 000010 (00h), 000011 (11h) and 000101 (00h), and store the whole byte. Outputs `adcEn`, `cdsEn`, `monoEn` and `fastMono` are bits 0, 1, 2 and 6 of the register at 000001.
- R7: Addresses 1000cc, 1001cc and 1010cc write the offset magnitude (full byte), the offset sign (data bit 0) and the gain code (data bits 4:0). cc = 00, 01 and 10 select channels 0, 1 and 2; cc = 11 writes all three. Per-channel reset values are 0.
- R8: `gainX4` for each channel equals its gain code + 2, which is the gain 0.5 + 0.25 × code expressed in quarter units.
- R9: A write to 000011 updates bits 5:2 always. It keeps the previous bits 1:0 (clamp level) when the new value is 11, and keeps the previous bits 7:6 (channel select) when the new value is 11.
- R10: Writes to 000000, to 000110 through 011111 and to 1011xx through 111111 change no register.
- R11: A write of any data to 000100 returns every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Hardware reset, active low, synchronous |
| enStb | input | 1 | Serial enable / parallel strobe (active low) |
| sdiDna | input | 1 | Serial data / parallel address-not-data select |
| sckRnw | input | 1 | Serial clock / parallel direction (1 = block drives bus) |
| busIn | input | 8 | Parallel byte input (bus bits 9:2) |
| busOe | output | 1 | Bus output enable for bus bits 9:2 |
| parMode | output | 1 | Latched port type, 1 = parallel |
| setup1 | output | 8 | Setup register at 000001 |
| setup2 | output | 8 | Setup register at 000010 |
| setup3 | output | 8 | Setup register at 000011 |
| setup4 | output | 8 | Setup register at 000101 |
| adcEn | output | 1 | Converter enable flag |
| cdsEn | output | 1 | Reset-sample (double sampling) enable flag |
| monoEn | output | 1 | Monochrome select flag |
| fastMono | output | 1 | 2:1 high-speed mode flag |
| offVal | output | 24 | Offset magnitudes, channel c at bits 8c+7:8c |
| offSign | output | 3 | Offset signs, channel c at bit c |
| gainCode | output | 15 | Gain codes, channel c at bits 5c+4:5c |
| gainX4 | output | 18 | Gain in quarter units, channel c at bits 6c+5:6c |

## Verification
Two functions can meet in one cycle: hardware reset release and edge detection on the shared strobe pin. In parallel mode the idle strobe level is high, so a synchroniser that leaves reset at zero would see a false rising edge at release. The bench provokes this by releasing reset with the strobe high, the select line on "address" and a valid setup address on the bus. It then sends a lone data byte and requires the setup register to keep its reset value. Broadcast writes, in which all three channel registers update in the same cycle, are swept in both port modes and compared channel by channel against a model of the register map.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } cfgWrite_t;

  localparam logic [ADDR_W-1:0] A_RSVD   = 6'b000000;
  localparam logic [ADDR_W-1:0] A_SETUP1 = 6'b000001;
  localparam logic [ADDR_W-1:0] A_SETUP2 = 6'b000010;
  localparam logic [ADDR_W-1:0] A_SETUP3 = 6'b000011;
  localparam logic [ADDR_W-1:0] A_SOFT   = 6'b000100;
  localparam logic [ADDR_W-1:0] A_SETUP4 = 6'b000101;

  localparam logic [3:0] G_OFFVAL  = 4'b1000;
  localparam logic [3:0] G_OFFSIGN = 4'b1001;
  localparam logic [3:0] G_GAIN    = 4'b1010;
  localparam logic [1:0] SEL_ALL   = 2'b11;

  localparam logic [DATA_W-1:0] D_SETUP1 = 8'h03;
  localparam logic [DATA_W-1:0] D_SETUP2 = 8'h00;
  localparam logic [DATA_W-1:0] D_SETUP3 = 8'h11;
  localparam logic [DATA_W-1:0] D_SETUP4 = 8'h00;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enStb,
  input  logic              sdiDna,
  input  logic              sckRnw,
  input  logic [DATA_W-1:0] busIn,
  output logic              parMode,
  output logic              busOe,
  output cfgWrite_t         wrOut
);
  localparam int SHIFT_W = ADDR_W + DATA_W;

  // synchronisers carry no reset so they track the pins through reset
  logic [SYNC_STAGES-1:0]        syncEn, syncDat, syncClk;
  logic [SYNC_STAGES*DATA_W-1:0] syncBus;
  logic enQ, datQ, clkQ;
  logic [DATA_W-1:0] busQ;

  always_ff @(posedge clk) begin
    syncEn  <= {syncEn[SYNC_STAGES-2:0], enStb};
    syncDat <= {syncDat[SYNC_STAGES-2:0], sdiDna};
    syncClk <= {syncClk[SYNC_STAGES-2:0], sckRnw};
    syncBus <= {syncBus[(SYNC_STAGES-1)*DATA_W-1:0], busIn};
    enQ     <= syncEn[SYNC_STAGES-1];
    datQ    <= syncDat[SYNC_STAGES-1];
    clkQ    <= syncClk[SYNC_STAGES-1];
    busQ    <= syncBus[SYNC_STAGES*DATA_W-1 -: DATA_W];
  end

  logic enS, datS, clkS;
  assign enS  = syncEn[SYNC_STAGES-1];
  assign datS = syncDat[SYNC_STAGES-1];
  assign clkS = syncClk[SYNC_STAGES-1];

  // port type: follows the pin during reset, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rstN) parMode <= enStb;
  end

  assign busOe = parMode & sckRnw;

  // serial path
  logic [SHIFT_W-1:0] shiftReg;
  logic sckRise, serCommit;
  assign sckRise   = !parMode && clkS && !clkQ;
  assign serCommit = !parMode && enS && !enQ;

  always_ff @(posedge clk) begin
    if (!rstN)        shiftReg <= '0;
    else if (sckRise) shiftReg <= {shiftReg[SHIFT_W-2:0], datS};
  end

  // parallel path: act when strobe returns high, using values from the low phase
  logic stbRise, parAddrEvt, parDataEvt;
  logic [ADDR_W-1:0] addrReg;
  logic addrValid;
  assign stbRise    = parMode && enS && !enQ && !clkQ;
  assign parAddrEvt = stbRise && !datQ;
  assign parDataEvt = stbRise && datQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      addrValid <= 1'b0;
    end else if (parAddrEvt) begin
      addrReg   <= busQ[ADDR_W-1:0];
      addrValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrOut <= '0;
    end else if (serCommit) begin
      wrOut <= '{wrEn: 1'b1, wrAddr: shiftReg[SHIFT_W-1 -: ADDR_W],
                 wrData: shiftReg[DATA_W-1:0]};
    end else if (parDataEvt && addrValid) begin
      wrOut <= '{wrEn: 1'b1, wrAddr: addrReg, wrData: busQ};
    end else begin
      wrOut.wrEn <= 1'b0;
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(parMode));  // R1

  AST_WRITE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    wrOut.wrEn |=> !wrOut.wrEn);  // R2
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_regs_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int GAIN_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfgWrite_t               wrIn,
  output logic [DATA_W-1:0]       setup1,
  output logic [DATA_W-1:0]       setup2,
  output logic [DATA_W-1:0]       setup3,
  output logic [DATA_W-1:0]       setup4,
  output logic [NCH*DATA_W-1:0]   offVal,
  output logic [NCH-1:0]          offSign,
  output logic [NCH*GAIN_W-1:0]   gainCode,
  output logic [NCH*(GAIN_W+1)-1:0] gainX4
);
  localparam int GX_W = GAIN_W + 1;

  logic softRst;
  logic [3:0] grp;
  logic [1:0] sel;
  assign softRst = wrIn.wrEn && (wrIn.wrAddr == A_SOFT);
  assign grp = wrIn.wrAddr[ADDR_W-1:2];
  assign sel = wrIn.wrAddr[1:0];

  logic [DATA_W-1:0] setup3Next;
  always_comb begin
    setup3Next      = wrIn.wrData;
    if (wrIn.wrData[1:0] == 2'b11) setup3Next[1:0] = setup3[1:0];
    if (wrIn.wrData[7:6] == 2'b11) setup3Next[7:6] = setup3[7:6];
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      setup1 <= D_SETUP1;
      setup2 <= D_SETUP2;
      setup3 <= D_SETUP3;
      setup4 <= D_SETUP4;
    end else if (wrIn.wrEn) begin
      case (wrIn.wrAddr)
        A_SETUP1: setup1 <= wrIn.wrData;
        A_SETUP2: setup2 <= wrIn.wrData;
        A_SETUP3: setup3 <= setup3Next;
        A_SETUP4: setup4 <= wrIn.wrData;
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : gCh
    logic hit;
    assign hit = wrIn.wrEn && ((sel == 2'(c)) || (sel == SEL_ALL));

    always_ff @(posedge clk) begin
      if (!rstN || softRst) begin
        offVal[c*DATA_W +: DATA_W]   <= '0;
        offSign[c]                   <= 1'b0;
        gainCode[c*GAIN_W +: GAIN_W] <= '0;
      end else if (hit) begin
        if (grp == G_OFFVAL)  offVal[c*DATA_W +: DATA_W]   <= wrIn.wrData;
        if (grp == G_OFFSIGN) offSign[c]                   <= wrIn.wrData[0];
        if (grp == G_GAIN)    gainCode[c*GAIN_W +: GAIN_W] <= wrIn.wrData[GAIN_W-1:0];
      end
    end

    assign gainX4[c*GX_W +: GX_W] = GX_W'(gainCode[c*GAIN_W +: GAIN_W]) + GX_W'(2);
  end

  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (wrIn.wrEn && wrIn.wrAddr == A_SOFT) |=>
      (setup1 == D_SETUP1 && setup2 == D_SETUP2 && setup3 == D_SETUP3 &&
       setup4 == D_SETUP4 && offSign == '0 && offVal == '0));  // R11

  AST_BROADCAST_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    (wrIn.wrEn && wrIn.wrAddr == {G_GAIN, SEL_ALL}) |=>
      (gainCode == {NCH{$past(wrIn.wrData[GAIN_W-1:0])}}));  // R7

  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (wrIn.wrEn && wrIn.wrAddr == A_RSVD) |=>
      ($stable(setup1) && $stable(setup3) && $stable(offVal) && $stable(gainCode)));  // R10

  AST_CLAMP_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    setup3[1:0] != 2'b11);  // R9
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_regs_pkg::*;
#(
  parameter int NCH         = 3,
  parameter int GAIN_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enStb,
  input  logic                      sdiDna,
  input  logic                      sckRnw,
  input  logic [7:0]                busIn,
  output logic                      busOe,
  output logic                      parMode,
  output logic [7:0]                setup1,
  output logic [7:0]                setup2,
  output logic [7:0]                setup3,
  output logic [7:0]                setup4,
  output logic                      adcEn,
  output logic                      cdsEn,
  output logic                      monoEn,
  output logic                      fastMono,
  output logic [NCH*8-1:0]          offVal,
  output logic [NCH-1:0]            offSign,
  output logic [NCH*GAIN_W-1:0]     gainCode,
  output logic [NCH*(GAIN_W+1)-1:0] gainX4
);
  cfgWrite_t wrBus;

  cfg_port_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .enStb(enStb), .sdiDna(sdiDna), .sckRnw(sckRnw),
    .busIn(busIn), .parMode(parMode), .busOe(busOe), .wrOut(wrBus)
  );

  cfg_reg_bank #(.NCH(NCH), .GAIN_W(GAIN_W)) uBank (
    .clk(clk), .rstN(rstN), .wrIn(wrBus),
    .setup1(setup1), .setup2(setup2), .setup3(setup3), .setup4(setup4),
    .offVal(offVal), .offSign(offSign), .gainCode(gainCode), .gainX4(gainX4)
  );

  assign adcEn    = setup1[0];
  assign cdsEn    = setup1[1];
  assign monoEn   = setup1[2];
  assign fastMono = setup1[6];
endmodule

// File: tb/cfg_port_regs_test.sv
module cfg_port_regs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enStb = 1'b0, sdiDna = 1'b0, sckRnw = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic busOe, parMode, adcEn, cdsEn, monoEn, fastMono;
  logic [7:0] setup1, setup2, setup3, setup4;
  logic [23:0] offVal;
  logic [2:0] offSign;
  logic [14:0] gainCode;
  logic [17:0] gainX4;

  always #5 clk = ~clk;

  cfg_port_regs uut (
    .clk(clk), .rstN(rstN), .enStb(enStb), .sdiDna(sdiDna), .sckRnw(sckRnw),
    .busIn(busIn), .busOe(busOe), .parMode(parMode),
    .setup1(setup1), .setup2(setup2), .setup3(setup3), .setup4(setup4),
    .adcEn(adcEn), .cdsEn(cdsEn), .monoEn(monoEn), .fastMono(fastMono),
    .offVal(offVal), .offSign(offSign), .gainCode(gainCode), .gainX4(gainX4)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;

  logic [7:0] mS1, mS2, mS3, mS4;
  logic [7:0] mOff[3];
  logic       mSgn[3];
  logic [4:0] mGain[3];
  logic       mPar;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic modelDefaults();
    mS1 = 8'h03; mS2 = 8'h00; mS3 = 8'h11; mS4 = 8'h00;
    for (int c = 0; c < 3; c++) begin mOff[c] = 0; mSgn[c] = 0; mGain[c] = 0; end
  endtask

  task automatic modelWrite(input logic [5:0] a, input logic [7:0] d);
    case (a)
      6'd1: mS1 = d;
      6'd2: mS2 = d;
      6'd3: begin
        if (d[1:0] != 2'b11) mS3[1:0] = d[1:0];
        mS3[5:2] = d[5:2];
        if (d[7:6] != 2'b11) mS3[7:6] = d[7:6];
      end
      6'd4: modelDefaults();
      6'd5: mS4 = d;
      default:
        for (int c = 0; c < 3; c++)
          if (a[1:0] == 2'(c) || a[1:0] == 2'b11) begin
            if (a[5:2] == 4'b1000) mOff[c] = d;
            if (a[5:2] == 4'b1001) mSgn[c] = d[0];
            if (a[5:2] == 4'b1010) mGain[c] = d[4:0];
          end
    endcase
  endtask

  function automatic string reqOf(input logic [5:0] a);
    if (a == 6'd1 || a == 6'd2 || a == 6'd5) return "R6";
    if (a == 6'd3) return "R9";
    if (a == 6'd4) return "R11";
    if (a[5:2] == 4'b1000 || a[5:2] == 4'b1001 || a[5:2] == 4'b1010) return "R7";
    return "R10";
  endfunction

  task automatic checkAll(input string tag);
    chk(tag, "setup1", setup1, mS1);
    chk(tag, "setup2", setup2, mS2);
    chk(tag, "setup3", setup3, mS3);
    chk(tag, "setup4", setup4, mS4);
    chk("R6", "flags", {fastMono, monoEn, cdsEn, adcEn}, {mS1[6], mS1[2], mS1[1], mS1[0]});
    for (int c = 0; c < 3; c++) begin
      chk(tag, $sformatf("offVal[%0d]", c), offVal[c*8 +: 8], mOff[c]);
      chk(tag, $sformatf("offSign[%0d]", c), offSign[c], mSgn[c]);
      chk(tag, $sformatf("gain[%0d]", c), gainCode[c*5 +: 5], mGain[c]);
      chk("R8", $sformatf("gainX4[%0d]", c), gainX4[c*6 +: 6], int'(mGain[c]) + 2);
    end
    chk("R1", "parMode", parMode, mPar);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwReset(input bit par, input logic [7:0] busAtRelease);
    rstN = 0; enStb = par; sdiDna = 0; sckRnw = 0; busIn = busAtRelease;
    waitN(6);
    rstN = 1;
    waitN(6);
    mPar = par;
    modelDefaults();
  endtask

  task automatic serWrite(input logic [5:0] a, input logic [7:0] d);
    logic [13:0] w;
    w = {a, d};
    for (int i = 13; i >= 0; i--) begin
      sdiDna = w[i]; waitN(4);
      sckRnw = 1;    waitN(4);
      sckRnw = 0;
    end
    waitN(4);
    enStb = 1; waitN(4);
    enStb = 0; waitN(8);
  endtask

  task automatic parByte(input bit dna, input logic [7:0] b, input bit rnw);
    sdiDna = dna; busIn = b; sckRnw = rnw; waitN(4);
    enStb = 0; waitN(4);
    enStb = 1; waitN(8);
    sckRnw = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    // serial mode, reset state
    hwReset(0, 8'h00);
    checkAll("R6 R7 R1");
    sckRnw = 1; waitN(1);
    chk("R5", "busOe serial rnw high", busOe, 0);
    sckRnw = 0; waitN(1);

    // serial sweep over every address
    for (int a = 0; a < 64; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 5) & 255);
      serWrite(6'(a), d);
      modelWrite(6'(a), d);
      checkAll({"R2 ", reqOf(6'(a))});
    end

    // reserved field codes in setup3
    serWrite(6'd3, 8'h9E); modelWrite(6'd3, 8'h9E);
    serWrite(6'd3, 8'hFF); modelWrite(6'd3, 8'hFF);
    checkAll("R9");
    chk("R9", "clamp kept", setup3[1:0], 2'b10);
    chk("R9", "chan kept", setup3[7:6], 2'b10);

    // broadcast of maximum gain
    serWrite(6'b101011, 8'hFF); modelWrite(6'b101011, 8'hFF);
    checkAll("R7");
    chk("R8", "gainX4 max ch2", gainX4[17:12], 33);

    // software reset in serial mode
    serWrite(6'd4, 8'h5A); modelWrite(6'd4, 8'h5A);
    checkAll("R11");

    // parallel mode, reset released with address-looking pins
    hwReset(1, 8'h01);
    chk("R1", "parMode latched", parMode, 1);
    parByte(1, 8'hAA, 0);
    chk("R4", "orphan data ignored", setup1, 8'h03);
    checkAll("R4");

    sckRnw = 1; waitN(1);
    chk("R5", "busOe parallel rnw high", busOe, 1);
    sckRnw = 0; waitN(1);
    chk("R5", "busOe parallel rnw low", busOe, 0);

    // parallel sweep over every address
    for (int a = 0; a < 64; a++) begin
      logic [7:0] d;
      d = 8'((a * 91 + 17) & 255);
      parByte(0, 8'(a), 0);
      parByte(1, d, 0);
      modelWrite(6'(a), d);
      checkAll({"R3 ", reqOf(6'(a))});
    end

    // address reuse across several data bytes
    parByte(0, 8'b00101001, 0);
    parByte(1, 8'h07, 0); modelWrite(6'b101001, 8'h07);
    parByte(1, 8'h13, 0); modelWrite(6'b101001, 8'h13);
    checkAll("R3");

    // strobe with direction high writes nothing
    parByte(0, 8'h01, 0);
    parByte(1, 8'h80, 0); modelWrite(6'd1, 8'h80);
    parByte(1, 8'h47, 1);
    chk("R3", "rnw high no write", setup1, 8'h80);
    checkAll("R3");

    // software reset keeps the port type
    parByte(0, 8'h04, 0);
    parByte(1, 8'h00, 0); modelWrite(6'd4, 8'h00);
    checkAll("R11");
    chk("R1", "parMode after soft reset", parMode, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule